// File: doc/BRIEF.md
# Two-Wire Memory Page-Write Sequencer

This block runs on the host side of a two-wire serial bus and sits above a bit-level bus engine. It takes one write request, made of a 7-bit target address and a word address, and a stream of data bytes. It turns them into a single page-write transfer: a start, the target address with the direction bit clear, the word address, the data bytes, and then a stop. The engine is driven through a command/response pair. A command is a start, a byte write or a stop. Each command gets exactly one response, and a response to a byte write carries the acknowledge bit sampled on the ninth clock.

After the stop, the target memory programs its page internally and refuses to acknowledge its own address while it is busy. The sequencer then probes it without any help from the host. Each probe is a start, the target address as a write, and a stop, so that no data phase follows. It repeats the probe until one is acknowledged, waiting a programmable number of idle cycles after every refused probe. The block ends the operation with a one-cycle `done` and a result code: success, a write refused, too many bytes for one page, or a poll timeout.

The controller has these states. ST_IDLE takes a request and goes to ST_W_START. The write phase runs ST_W_START, then ST_W_DEV, then ST_W_ADDR, which repeats once per address byte. ST_W_FETCH takes one stream byte and ST_W_DATA sends it, and the two alternate until the byte flagged last has been sent, which leads to ST_W_STOP. A refused byte, or a page that fills before the last flag arrives, leads to ST_W_DRAIN. ST_W_DRAIN discards bytes up to the last flag and then goes to ST_W_STOP. ST_W_STOP leads to ST_FINISH after a refusal, and to ST_P_START otherwise. The poll phase runs ST_P_START, then ST_P_DEV, then ST_P_STOP. From ST_P_STOP, an accepted probe or an exhausted limit leads to ST_FINISH, and any other refused probe leads to ST_P_GAP, which returns to ST_P_START. ST_FINISH returns to ST_IDLE.

Top module: `eeprom_page_sequencer`

## Requirements
- R1: After reset, and whenever no operation runs, `req_ready` is 1 and `cmd_valid`, `dat_ready` and `done` are 0. A request is taken in any cycle where `req_valid` and `req_ready` are both high.
- R2: The write phase issues these commands in order: start (op 0), a byte write (op 1) of `{req_dev, 1'b0}`, the word address bytes with the most significant byte first, then one byte write per stream byte in stream order. No stop comes between them.
- R3: Once the stream byte flagged `dat_last` has been acknowledged, the next command is a stop (op 2).
- R4: At most PAGE_BYTES data bytes are written. If byte number PAGE_BYTES is not flagged last, the rest of the stream is taken and discarded up to and including the last-flagged byte, and a stop follows. Polling then runs, and a successful poll ends with result 2.
- R5: A refusal (`rsp_nack` = 1) of any write-phase byte is followed by a stop. Unread stream bytes are discarded up to and including the last-flagged one. No poll follows, and the result is 1.
- R6: After the write-phase stop, the next command is presented in the cycle after its response. Each poll is a start, a byte write of `{req_dev, 1'b0}` and a stop, with no data phase.
- R7: An accepted poll ends the operation with `done` and result 0, or result 2 after an overflow.
- R8: After the response to the stop of a refused poll, `cmd_valid` stays low for `poll_gap`+1 cycles, and then the next start is presented.
- R9: When POLL_LIMIT polls in a row are refused, the operation ends with result 3, and no further command is issued.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_byte` hold. Only one command is outstanding until its response arrives.
- R11: `done` is high for exactly one cycle, and `req_ready` is high in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_dev | input | 7 | Target address |
| req_addr | input | ADDR_BYTES*8 | Word address inside the target |
| dat_valid | input | 1 | Stream byte offered |
| dat_ready | output | 1 | Stream byte taken this cycle |
| dat_byte | input | 8 | Stream data byte |
| dat_last | input | 1 | Marks the final byte of the burst |
| poll_gap | input | GAP_W | Idle cycles between polls, less one |
| cmd_valid | output | 1 | Bus command presented |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_op | output | 2 | 0 start, 1 byte write, 2 stop |
| cmd_byte | output | 8 | Byte for a write command |
| rsp_valid | input | 1 | Engine finished the outstanding command |
| rsp_nack | input | 1 | Ninth-clock acknowledge missing |
| done | output | 1 | Operation finished, one cycle |
| result | output | 2 | 0 ok, 1 write refused, 2 overflow, 3 poll timeout |

## Verification
The hardest cases to reach from the ports are a refusal on a chosen byte, and a target that stays busy for exactly a chosen number of probes. The behavioural engine in the bench counts the byte writes and polls it receives. It refuses the write whose index was set for the case and the first N polls. The bench sweeps every refusal index across the device, address and data bytes, and every busy count from zero up past the poll limit. It crosses these with several burst lengths on both sides of a small page and with several gap values, and adds a set of cases in which the engine stalls commands.

// File: rtl/epseq_pkg.sv
package epseq_pkg;

    typedef enum logic [1:0] {
        BUS_START = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_STOP  = 2'd2
    } bus_op_e;

    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_NACK     = 2'd1,
        RES_OVERFLOW = 2'd2,
        RES_TIMEOUT  = 2'd3
    } result_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_START,
        ST_W_DEV,
        ST_W_ADDR,
        ST_W_FETCH,
        ST_W_DATA,
        ST_W_DRAIN,
        ST_W_STOP,
        ST_P_START,
        ST_P_DEV,
        ST_P_STOP,
        ST_P_GAP,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/epseq_addr_sel.sv
module epseq_addr_sel #(
    parameter int ADDR_BYTES = 2,
    parameter int AIDX_W     = 1
) (
    input  logic [ADDR_BYTES*8-1:0] addr,
    input  logic [AIDX_W-1:0]       idx,
    output logic [7:0]              sel_byte
);

    logic [7:0] lane [ADDR_BYTES];

    // lane 0 holds the most significant byte: it goes out first
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        assign lane[g] = addr[(ADDR_BYTES-1-g)*8 +: 8];
    end

    if (ADDR_BYTES == 1) begin : g_single
        logic unused_idx;
        assign unused_idx = ^idx;
        assign sel_byte   = lane[0];
    end else begin : g_multi
        assign sel_byte = lane[idx];
    end

endmodule

// File: rtl/epseq_gap_timer.sv
module epseq_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] gap,
    output logic             expired
);

    logic [GAP_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= gap;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/epseq_poll_counter.sv
module epseq_poll_counter #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);

    localparam int PW = $clog2(LIMIT + 1);
    localparam logic [PW-1:0] LAST_VAL = PW'(LIMIT - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_last = (cnt_q == LAST_VAL);

endmodule

// File: rtl/eeprom_page_sequencer.sv
module eeprom_page_sequencer
    import epseq_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int ADDR_BYTES = 2,
    parameter int POLL_LIMIT = 1000,
    parameter int GAP_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [6:0]              req_dev,
    input  logic [ADDR_BYTES*8-1:0] req_addr,
    input  logic                    dat_valid,
    output logic                    dat_ready,
    input  logic [7:0]              dat_byte,
    input  logic                    dat_last,
    input  logic [GAP_W-1:0]        poll_gap,
    output logic                    cmd_valid,
    input  logic                    cmd_ready,
    output logic [1:0]              cmd_op,
    output logic [7:0]              cmd_byte,
    input  logic                    rsp_valid,
    input  logic                    rsp_nack,
    output logic                    done,
    output logic [1:0]              result
);

    localparam int AW     = ADDR_BYTES * 8;
    localparam int CNT_W  = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
    localparam int AIDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(PAGE_BYTES - 1);
    localparam logic [AIDX_W-1:0] AIDX_LAST = AIDX_W'(ADDR_BYTES - 1);

    seq_state_e        state_q, state_d;
    logic              issued_q;
    logic [6:0]        dev_q;
    logic [AW-1:0]     addr_q;
    logic [7:0]        byte_q;
    logic              last_q;
    logic [CNT_W-1:0]  bcnt_q;
    logic [AIDX_W-1:0] aidx_q;
    result_e           err_q;
    logic              poll_ok_q;

    logic              rsp_hit;
    logic [7:0]        addr_byte;
    logic              gap_done;
    logic              poll_last;
    logic              poll_refused;
    bus_op_e           op_w;

    assign rsp_hit      = issued_q && rsp_valid;
    assign poll_refused = (state_q == ST_P_STOP) && rsp_hit && !poll_ok_q;

    epseq_addr_sel #(
        .ADDR_BYTES (ADDR_BYTES),
        .AIDX_W     (AIDX_W)
    ) addr_sel_i (
        .addr     (addr_q),
        .idx      (aidx_q),
        .sel_byte (addr_byte)
    );

    epseq_gap_timer #(
        .GAP_W (GAP_W)
    ) gap_timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (poll_refused),
        .gap     (poll_gap),
        .expired (gap_done)
    );

    epseq_poll_counter #(
        .LIMIT (POLL_LIMIT)
    ) poll_counter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == ST_IDLE),
        .inc     (poll_refused),
        .at_last (poll_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_W_START;
            ST_W_START: if (rsp_hit) state_d = ST_W_DEV;
            ST_W_DEV:   if (rsp_hit) state_d = rsp_nack ? ST_W_DRAIN : ST_W_ADDR;
            ST_W_ADDR: begin
                if (rsp_hit) begin
                    if (rsp_nack)                 state_d = ST_W_DRAIN;
                    else if (aidx_q == AIDX_LAST) state_d = ST_W_FETCH;
                end
            end
            ST_W_FETCH: if (dat_valid) state_d = ST_W_DATA;
            ST_W_DATA: begin
                if (rsp_hit) begin
                    if (rsp_nack)                state_d = last_q ? ST_W_STOP : ST_W_DRAIN;
                    else if (last_q)             state_d = ST_W_STOP;
                    else if (bcnt_q == CNT_LAST) state_d = ST_W_DRAIN;
                    else                         state_d = ST_W_FETCH;
                end
            end
            ST_W_DRAIN: if (dat_valid && dat_last) state_d = ST_W_STOP;
            ST_W_STOP:  if (rsp_hit) state_d = (err_q == RES_NACK) ? ST_FINISH : ST_P_START;
            ST_P_START: if (rsp_hit) state_d = ST_P_DEV;
            ST_P_DEV:   if (rsp_hit) state_d = ST_P_STOP;
            ST_P_STOP: begin
                if (rsp_hit) begin
                    if (poll_ok_q || poll_last) state_d = ST_FINISH;
                    else                        state_d = ST_P_GAP;
                end
            end
            ST_P_GAP:   if (gap_done) state_d = ST_P_START;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        dat_ready = 1'b0;
        cmd_valid = 1'b0;
        op_w      = BUS_START;
        cmd_byte  = 8'h00;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_W_START, ST_P_START: begin
                cmd_valid = !issued_q;
                op_w      = BUS_START;
            end
            ST_W_DEV, ST_P_DEV: begin
                cmd_valid = !issued_q;
                op_w      = BUS_WRITE;
                cmd_byte  = {dev_q, 1'b0};
            end
            ST_W_ADDR: begin
                cmd_valid = !issued_q;
                op_w      = BUS_WRITE;
                cmd_byte  = addr_byte;
            end
            ST_W_DATA: begin
                cmd_valid = !issued_q;
                op_w      = BUS_WRITE;
                cmd_byte  = byte_q;
            end
            ST_W_FETCH, ST_W_DRAIN: dat_ready = 1'b1;
            ST_W_STOP, ST_P_STOP: begin
                cmd_valid = !issued_q;
                op_w      = BUS_STOP;
            end
            ST_P_GAP:  ;
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
        cmd_op = op_w;
        result = err_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued_q  <= 1'b0;
            dev_q     <= '0;
            addr_q    <= '0;
            byte_q    <= '0;
            last_q    <= 1'b0;
            bcnt_q    <= '0;
            aidx_q    <= '0;
            err_q     <= RES_OK;
            poll_ok_q <= 1'b0;
        end else begin
            if (rsp_hit) begin
                issued_q <= 1'b0;
            end else if (cmd_valid && cmd_ready) begin
                issued_q <= 1'b1;
            end
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        dev_q  <= req_dev;
                        addr_q <= req_addr;
                        last_q <= 1'b0;
                        bcnt_q <= '0;
                        aidx_q <= '0;
                        err_q  <= RES_OK;
                    end
                end
                ST_W_DEV: begin
                    if (rsp_hit && rsp_nack) err_q <= RES_NACK;
                end
                ST_W_ADDR: begin
                    if (rsp_hit) begin
                        if (rsp_nack) err_q  <= RES_NACK;
                        else          aidx_q <= aidx_q + 1'b1;
                    end
                end
                ST_W_FETCH: begin
                    if (dat_valid) begin
                        byte_q <= dat_byte;
                        last_q <= dat_last;
                    end
                end
                ST_W_DATA: begin
                    if (rsp_hit) begin
                        if (rsp_nack) begin
                            err_q <= RES_NACK;
                        end else if (!last_q) begin
                            if (bcnt_q == CNT_LAST) err_q  <= RES_OVERFLOW;
                            else                    bcnt_q <= bcnt_q + 1'b1;
                        end
                    end
                end
                ST_P_DEV: begin
                    if (rsp_hit) poll_ok_q <= !rsp_nack;
                end
                ST_P_STOP: begin
                    if (poll_refused && poll_last) err_q <= RES_TIMEOUT;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/epseq_checker.sv
module epseq_checker
    import epseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       dat_ready,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_op,
    input logic [7:0] cmd_byte,
    input logic       done,
    input logic [1:0] result,
    input seq_state_e state
);

    assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)))
        else $error("command changed while stalled");

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready))
        else $error("done not a single pulse");

    assert_phase_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, dat_ready, cmd_valid, done}))
        else $error("phases overlap");

    assert_no_stream_in_poll_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_P_START, ST_P_DEV, ST_P_STOP, ST_P_GAP}) |-> !dat_ready)
        else $error("stream taken while polling");

    assert_op_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op != 2'd3))
        else $error("illegal command op");

    assert_timeout_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd3) |=> !cmd_valid)
        else $error("command after timeout");

endmodule

bind eeprom_page_sequencer epseq_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .dat_ready (dat_ready),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .done      (done),
    .result    (result),
    .state     (state_q)
);

// File: tb/eeprom_page_sequencer_tb_top.sv
module eeprom_page_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int P  = 4;
    localparam int AB = 2;
    localparam int L  = 3;
    localparam int GW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [6:0]    req_dev = '0;
    logic [15:0]   req_addr = '0;
    logic          dat_valid, dat_ready, dat_last;
    logic [7:0]    dat_byte;
    logic [GW-1:0] poll_gap = '0;
    logic          cmd_valid, cmd_ready;
    logic [1:0]    cmd_op;
    logic [7:0]    cmd_byte;
    logic          rsp_valid, rsp_nack;
    logic          done;
    logic [1:0]    result;

    int checks = 0;
    int errors = 0;

    // data stream source
    logic [7:0] sbyte [16];
    int slen = 0;
    int sidx = 0;
    assign dat_valid = (sidx < slen);
    assign dat_byte  = sbyte[sidx[3:0]];
    assign dat_last  = dat_valid && (sidx == slen - 1);
    always @(posedge clk) begin
        if (!rst_n) sidx <= 0;
        else if (dat_valid && dat_ready) sidx <= sidx + 1;
    end

    // behavioural bus engine
    int cfg_k = -1;
    int cfg_b = 0;
    int cfg_stall = 0;
    logic [1:0] log_op [64];
    logic [7:0] log_byte [64];
    int log_t [64];
    int nlog = 0, wr_cnt = 0, stops = 0, polls = 0, cyc = 0;

    assign cmd_ready = (cfg_stall == 0) || (cyc % 3 == 2);

    always @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_nack  <= 1'b0;
            nlog <= 0; wr_cnt <= 0; stops <= 0; polls <= 0; cyc <= 0;
        end else begin
            cyc       <= cyc + 1;
            rsp_valid <= 1'b0;
            if (cmd_valid && cmd_ready) begin
                if (nlog < 64) begin
                    log_op[nlog]   <= cmd_op;
                    log_byte[nlog] <= cmd_byte;
                    log_t[nlog]    <= cyc;
                end
                nlog      <= nlog + 1;
                rsp_valid <= 1'b1;
                rsp_nack  <= 1'b0;
                if (cmd_op == 2'd2) stops <= stops + 1;
                if (cmd_op == 2'd1) begin
                    if (stops == 0) begin
                        rsp_nack <= (wr_cnt == cfg_k);
                        wr_cnt   <= wr_cnt + 1;
                    end else begin
                        rsp_nack <= (polls < cfg_b);
                        polls    <= polls + 1;
                    end
                end
            end
        end
    end

    eeprom_page_sequencer #(
        .PAGE_BYTES (P),
        .ADDR_BYTES (AB),
        .POLL_LIMIT (L),
        .GAP_W      (GW)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_dev   (req_dev),
        .req_addr  (req_addr),
        .dat_valid (dat_valid),
        .dat_ready (dat_ready),
        .dat_byte  (dat_byte),
        .dat_last  (dat_last),
        .poll_gap  (poll_gap),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_byte  (cmd_byte),
        .rsp_valid (rsp_valid),
        .rsp_nack  (rsp_nack),
        .done      (done),
        .result    (result)
    );

    // expected command list
    logic [1:0] exp_op [64];
    logic [7:0] exp_byte [64];
    int exp_dt [64];
    int nexp;
    int exp_res;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic add_exp(input logic [1:0] op, input logic [7:0] b, input int dt);
        exp_op[nexp]   = op;
        exp_byte[nexp] = b;
        exp_dt[nexp]   = dt;
        nexp++;
    endtask

    task automatic build_exp(input int n, input int k, input int b, input int g);
        int wcount;
        bit refused;
        logic [7:0] wb;
        nexp    = 0;
        refused = 0;
        wcount  = 3 + ((n < P) ? n : P);
        add_exp(2'd0, 8'h00, -1);
        for (int i = 0; i < wcount; i++) begin
            if (i == 0)      wb = {req_dev, 1'b0};
            else if (i == 1) wb = req_addr[15:8];
            else if (i == 2) wb = req_addr[7:0];
            else             wb = sbyte[i-3];
            add_exp(2'd1, wb, -1);
            if (i == k) begin
                refused = 1;
                break;
            end
        end
        add_exp(2'd2, 8'h00, -1);
        if (refused) begin
            exp_res = 1;
            return;
        end
        exp_res = (n > P) ? 2 : 0;
        for (int j = 0; j < L; j++) begin
            add_exp(2'd0, 8'h00, (j == 0) ? 2 : g + 3);
            add_exp(2'd1, {req_dev, 1'b0}, 2);
            add_exp(2'd2, 8'h00, 2);
            if (j >= b) break;
            if (j == L - 1) exp_res = 3;
        end
    endtask

    task automatic run_case(input int n, input int k, input int b, input int g,
                            input int stall, input int id);
        int wait_cnt;
        int nlog_done;
        bit seq_ok;
        bit dt_ok;
        int bad_i;
        string rtag;
        rst_n     = 1'b0;
        cfg_k     = k;
        cfg_b     = b;
        cfg_stall = stall;
        slen      = n;
        for (int i = 0; i < 16; i++) sbyte[i] = 8'(id * 29 + i * 53 + 7);
        req_dev   = 7'h50 + 7'(id % 8);
        req_addr  = 16'(id * 4099 + 165);
        poll_gap  = GW'(g);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        build_exp(n, k, b, g);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_cnt = 0;
        while (!done && wait_cnt < 3000) begin
            @(negedge clk);
            wait_cnt++;
        end
        if (!done) begin
            check(0, "R7", "watchdog: no done", 0, 1);
            return;
        end
        case (exp_res)
            1:       rtag = "R5";
            2:       rtag = "R4";
            3:       rtag = "R9";
            default: rtag = "R7";
        endcase
        check(result == 2'(exp_res), rtag, "result code", int'(result), exp_res);
        // R11: req_ready in the cycle after done
        @(negedge clk);
        check(req_ready && !done, "R11", "ready after done pulse", int'(req_ready), 1);
        nlog_done = nlog;
        repeat (5) @(negedge clk);
        // R9: no commands after the end
        check(nlog == nlog_done, "R9", "commands after done", nlog, nlog_done);
        check(nlog == nexp, "R2 R6", "command count", nlog, nexp);
        seq_ok = 1;
        bad_i  = 0;
        for (int i = 0; i < nexp && i < nlog; i++) begin
            if (seq_ok && (log_op[i] != exp_op[i] || log_byte[i] != exp_byte[i])) begin
                seq_ok = 0;
                bad_i  = i;
            end
        end
        // R2, R3: write order and stop after last byte; R6: poll shape
        check(seq_ok, "R2 R3 R6", $sformatf("command %0d op/byte", bad_i),
              int'({log_op[bad_i], log_byte[bad_i]}), int'({exp_op[bad_i], exp_byte[bad_i]}));
        // R4, R5: stream drained through the last byte
        check(sidx == slen, (exp_res == 1) ? "R5" : "R4", "stream bytes taken", sidx, slen);
        if (stall == 0) begin
            dt_ok = 1;
            bad_i = 0;
            for (int i = 1; i < nexp && i < nlog; i++) begin
                if (dt_ok && exp_dt[i] >= 0 && (log_t[i] - log_t[i-1]) != exp_dt[i]) begin
                    dt_ok = 0;
                    bad_i = i;
                end
            end
            // R8: gap between refused poll and next start
            check(dt_ok, "R8", $sformatf("spacing before command %0d", bad_i),
                  log_t[bad_i] - ((bad_i > 0) ? log_t[bad_i-1] : 0), exp_dt[bad_i]);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual 190000 expected fewer cycles");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int id;
        id = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
        check(cmd_valid == 1'b0, "R1", "cmd_valid after reset", int'(cmd_valid), 0);
        check(dat_ready == 1'b0, "R1", "dat_ready after reset", int'(dat_ready), 0);
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(req_ready && !cmd_valid, "R1", "idle without request", int'(cmd_valid), 0);

        // burst length x busy count x gap
        for (int n = 1; n <= P + 2; n++)
            for (int b = 0; b <= L; b++)
                for (int g = 0; g <= 2; g++) begin
                    run_case(n, -1, b, g, 0, id);
                    id++;
                end
        // refusal at every write index
        for (int n = 1; n <= P + 1; n++) begin
            int wmax;
            wmax = 3 + ((n < P) ? n : P);
            for (int k = 0; k < wmax; k++) begin
                run_case(n, k, 0, 0, 0, id);
                id++;
            end
        end
        // R10: engine stalls commands
        for (int n = 1; n <= P + 2; n++) begin
            run_case(n, -1, 1, 1, 1, id);
            id++;
        end
        run_case(3, 4, 0, 0, 1, id);
        id++;
        run_case(2, -1, L, 0, 1, id);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule